// File: doc/BRIEF.md
# Programmable Timer with Capture

This block is one 16-bit timer channel behind a small synchronous register bus. A counter advances on prescaled ticks taken from one of three sources: the system clock, the system clock divided by sixteen, or rising edges of an external pin. When the counter reaches a programmed reference value, the block raises a reference event. Each channel is set up to either wrap back to zero after the match or keep counting through it.

The same external pin is synchronised and edge-detected. On a selected edge, the block copies the live counter into a capture register and raises a capture event. Both events are cleared by software writing ones to them, and together they drive a single level interrupt line. Software uses the block in a fixed order: it programs the mode, reference and counter registers, releases the timer through the control word, and then services the interrupt.

Top module: `gp_capture_timer`

## Requirements
- R1: The registers sit at word addresses 0 control, 1 mode, 2 reference, 3 capture, 4 counter and 5 event, and reads are combinational. After reset every register reads 0 and `irq` is low.
- R2: Mode bits 15:8 hold a prescale value P. The counter advances once per P+1 source ticks.
- R3: Mode bits 2:1 choose the source tick. Code 01 gives one tick per system clock, code 10 one tick per 16 system clocks, and code 00 gives no ticks.
- R4: With code 11 in mode bits 2:1, each rising edge of `tmr_pin` gives one source tick, after a two-flop synchroniser.
- R5: With mode bit 3 set, the counter goes from the reference value to 0 on the next tick. With it clear, the counter runs past the reference and wraps from 0xFFFF to 0.
- R6: Event bit 1 is set on the tick that brings the counter to the reference value.
- R7: Mode bits 7:6 pick the capture edge of `tmr_pin`: 00 none, 01 rising, 10 falling, 11 both. On a selected edge, the counter value is copied into the capture register and event bit 0 is set.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R9: While control bit 0 is low, the counter and the prescale state are held at zero and nothing counts. With bits 1:0 = 11, counting stops and the counter keeps its value.
- R10: A bus write to the counter loads the written value. Writes to the capture register are ignored.
- R11: Mode bit 0 and mode bit 5 are stored and read back, and they have no effect on counting.
- R12: `irq` is high exactly when event bit 1 is set with mode bit 4 set, or when event bit 0 is set with mode bits 7:6 nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tmr_pin | input | 1 | Asynchronous external count and capture input |
| irq | output | 1 | Level interrupt request |

## Verification
Faults in the prescale or divide state show up as a wrong counter value at the next read of the counter. That read can come after a known number of edges, because stopping the timer freezes the count. A bad synchroniser or a wrong edge decode shows up three clocks after a pin transition, as a wrong capture value or a wrong event bit. Errors in the match, restart and wrap logic show up in the counter and event registers within a few ticks of the reference value. Interrupt masking faults are visible on `irq` in the same cycle that an event or mode bit changes.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_MODE = 3'd1,
        A_REF  = 3'd2,
        A_CAP  = 3'd3,
        A_CNT  = 3'd4,
        A_EVT  = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_SYS    = 2'b01,
        SRC_SYSDIV = 2'b10,
        SRC_PIN    = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_BOTH = 2'b11
    } cap_e;

    typedef struct packed {
        logic [7:0] presc;
        cap_e       cap_sel;
        logic       out_mode;
        logic       ref_irq_en;
        logic       restart;
        src_e       src;
        logic       gate_en;
    } mode_t;

    function automatic logic cap_edge_hit(cap_e sel, logic rise, logic fall);
        case (sel)
            CAP_RISE: return rise;
            CAP_FALL: return fall;
            CAP_BOTH: return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    logic              lvl;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign lvl = sh_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen
    import gpt_pkg::*;
#(
    parameter int PS_W  = 8,
    parameter int DIV_N = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            run,
    input  src_e            src,
    input  logic [PS_W-1:0] presc,
    input  logic            pin_rise,
    output logic            cnt_tick
);
    localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;

    logic [DIV_W-1:0] div_q;
    logic [PS_W-1:0]  pre_q;
    logic             div_tick;
    logic             src_tick;
    logic             pre_wrap;

    assign div_tick = (div_q == DIV_W'(DIV_N - 1));

    always_comb begin
        case (src)
            SRC_SYS:    src_tick = 1'b1;
            SRC_SYSDIV: src_tick = div_tick;
            SRC_PIN:    src_tick = pin_rise;
            default:    src_tick = 1'b0;
        endcase
    end

    assign pre_wrap = (pre_q == presc);
    assign cnt_tick = run & src_tick & pre_wrap;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_tick ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (run && src_tick) begin
            pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] ref_val,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_val,
    output logic [W-1:0] cnt_q,
    output logic         ref_hit
);
    logic [W-1:0] nxt;

    always_comb begin
        if (restart && (cnt_q == ref_val)) nxt = '0;
        else                               nxt = cnt_q + 1'b1;
    end

    assign ref_hit = tick & ~sw_wr & ~clr & (nxt == ref_val);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (sw_wr)  cnt_q <= sw_val;
        else if (tick)   cnt_q <= nxt;
    end
endmodule

// File: rtl/gp_capture_timer.sv
module gp_capture_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_N       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tmr_pin,
    output logic              irq
);
    localparam int PS_W = 8;

    logic [1:0]       ctrl_q;
    mode_t            mode_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] cap_q;
    logic [1:0]       evt_q;
    logic [CNT_W-1:0] cnt_q;

    logic             cnt_wr, evt_wr;
    logic             tmr_clr, tmr_run;
    logic             pin_rise, pin_fall;
    logic             cnt_tick, ref_hit, cap_fire;
    logic [1:0]       evt_clr;

    assign cnt_wr  = bus_we && (bus_addr == A_CNT);
    assign evt_wr  = bus_we && (bus_addr == A_EVT);
    assign tmr_clr = ~ctrl_q[0];
    assign tmr_run = ctrl_q[0] & ~ctrl_q[1];

    gpt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (tmr_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    gpt_tick_gen #(.PS_W(PS_W), .DIV_N(DIV_N)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .run      (tmr_run),
        .src      (mode_q.src),
        .presc    (mode_q.presc),
        .pin_rise (pin_rise),
        .cnt_tick (cnt_tick)
    );

    gpt_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .tick    (cnt_tick),
        .restart (mode_q.restart),
        .ref_val (ref_q),
        .sw_wr   (cnt_wr),
        .sw_val  (bus_wdata[CNT_W-1:0]),
        .cnt_q   (cnt_q),
        .ref_hit (ref_hit)
    );

    assign cap_fire = cap_edge_hit(mode_q.cap_sel, pin_rise, pin_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ref_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= bus_wdata[1:0];
                A_MODE:  mode_q <= mode_t'(bus_wdata);
                A_REF:   ref_q  <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cap_q <= '0;
        else if (cap_fire) cap_q <= cnt_q;
    end

    assign evt_clr = evt_wr ? bus_wdata[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= (evt_q & ~evt_clr) | {ref_hit, cap_fire};
    end

    assign irq = (evt_q[1] & mode_q.ref_irq_en) |
                 (evt_q[0] & (mode_q.cap_sel != CAP_OFF));

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = REG_W'(ctrl_q);
            A_MODE:  bus_rdata = mode_q;
            A_REF:   bus_rdata = REG_W'(ref_q);
            A_CAP:   bus_rdata = REG_W'(cap_q);
            A_CNT:   bus_rdata = REG_W'(cnt_q);
            A_EVT:   bus_rdata = REG_W'(evt_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       ctrl_q,
    input logic [15:0]      mode_bits,
    input logic [CNT_W-1:0] ref_q,
    input logic [CNT_W-1:0] cap_q,
    input logic [1:0]       evt_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cnt_wr,
    input logic             evt_wr,
    input logic [15:0]      wdata,
    input logic             cnt_tick,
    input logic             ref_hit,
    input logic             cap_fire,
    input logic             irq
);
    // R9: held in reset, the counter is zero on the next cycle
    a_r9_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[0] |=> (cnt_q == '0));

    // R9: stopped, the counter keeps its value unless software writes it
    a_r9_stop_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q == 2'b11 && !cnt_wr) |=> $stable(cnt_q));

    // R8: writing one clears the reference event unless a new match sets it
    a_r8_w1c_ref: assert property (@(posedge clk) disable iff (rst)
        (evt_wr && wdata[1] && !ref_hit) |=> !evt_q[1]);

    // R7: a capture copies the live counter and raises the capture event
    a_r7_capture_copy: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> ((cap_q == $past(cnt_q)) && evt_q[0]));

    // R5: in restart mode a tick at the reference brings the counter to zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && mode_bits[3] && (cnt_q == ref_q) && !cnt_wr && ctrl_q[0])
        |=> (cnt_q == '0));

    // R6: a match always lands in the event register
    a_r6_ref_event_set: assert property (@(posedge clk) disable iff (rst)
        ref_hit |=> evt_q[1]);

    // R12: no interrupt without a pending event
    a_r12_irq_needs_event: assert property (@(posedge clk) disable iff (rst)
        irq |-> (evt_q != 2'b00));
endmodule

bind gp_capture_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_q    (ctrl_q),
    .mode_bits (mode_q),
    .ref_q     (ref_q),
    .cap_q     (cap_q),
    .evt_q     (evt_q),
    .cnt_q     (cnt_q),
    .cnt_wr    (cnt_wr),
    .evt_wr    (evt_wr),
    .wdata     (bus_wdata),
    .cnt_tick  (cnt_tick),
    .ref_hit   (ref_hit),
    .cap_fire  (cap_fire),
    .irq       (irq)
);

// File: tb/gp_capture_timer_tb.sv
`timescale 1ns/1ps
module gp_capture_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tmr_pin = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    gp_capture_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_pin   (tmr_pin),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    localparam logic [2:0] CTRL = 3'd0, MODE = 3'd1, REFR = 3'd2,
                           CAPR = 3'd3, CNTR = 3'd4, EVTR = 3'd5;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            #1;
            begin
                exp_t it;
                logic [15:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {15'b0, irq} : bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        sb_q.push_back('{0, e, tag});
        -> mon_ev;
        #2;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        sb_q.push_back('{1, {15'b0, e}, tag});
        -> mon_ev;
        #2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_set(input logic v);
        @(negedge clk);
        tmr_pin = v;
        idle(5);
    endtask

    initial begin
        #(1000us);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) chk_reg(3'(a), 16'h0000, "R1 reset value");
        chk_irq(1'b0, "R1 irq after reset");

        // R2 / R11: divide by 4 from system clock, gate and output-mode bits set
        wr(REFR, 16'hFFFF);
        wr(MODE, 16'h0323);
        wr(CTRL, 16'h0001);
        idle(10);
        wr(CTRL, 16'h0003);
        chk_reg(MODE, 16'h0323, "R11 mode readback");
        chk_reg(CNTR, 16'd3, "R2 prescale divide 4 over 12 clocks");
        idle(8);
        chk_reg(CNTR, 16'd3, "R9 stop holds count");
        wr(CTRL, 16'h0000);
        chk_reg(CNTR, 16'd0, "R9 held in reset clears counter");

        // R3: divided-by-16 source, 34 counting edges give 2
        wr(MODE, 16'h0004);
        wr(CTRL, 16'h0001);
        idle(32);
        wr(CTRL, 16'h0003);
        chk_reg(CNTR, 16'd2, "R3 sysclk/16 source");

        // R5 / R6: restart at reference 4, 12 ticks give 2
        wr(CTRL, 16'h0000);
        wr(REFR, 16'd4);
        wr(MODE, 16'h0008 | 16'h0002);
        wr(CTRL, 16'h0001);
        idle(10);
        wr(CTRL, 16'h0003);
        chk_reg(CNTR, 16'd2, "R5 restart period ref+1");
        chk_reg(EVTR, 16'h0002, "R6 reference event set");
        chk_irq(1'b0, "R12 ref event masked");
        wr(MODE, 16'h0008 | 16'h0002 | 16'h0010);
        chk_irq(1'b1, "R12 ref event enabled");
        wr(EVTR, 16'h0001);
        chk_reg(EVTR, 16'h0002, "R8 writing zero keeps bit");
        wr(EVTR, 16'h0002);
        chk_reg(EVTR, 16'h0000, "R8 write one clears");
        chk_irq(1'b0, "R12 irq drops after clear");

        // R5 free run: wraps and passes the reference
        wr(MODE, 16'h0012);
        wr(REFR, 16'd1);
        wr(CNTR, 16'hFFFE);
        chk_reg(CNTR, 16'hFFFE, "R10 counter load");
        wr(CTRL, 16'h0001);
        idle(2);
        wr(CTRL, 16'h0003);
        chk_reg(CNTR, 16'd2, "R5 free run wrap past reference");
        chk_reg(EVTR, 16'h0002, "R6 event on free-run match");
        wr(EVTR, 16'h0003);

        // R7 capture edges (timer stopped, counter loaded by software)
        wr(MODE, 16'h0042);
        wr(CNTR, 16'h1234);
        pin_set(1'b1);
        chk_reg(CAPR, 16'h1234, "R7 rising capture");
        chk_reg(EVTR, 16'h0001, "R7 capture event");
        chk_irq(1'b1, "R12 capture irq");
        wr(CNTR, 16'h2222);
        pin_set(1'b0);
        chk_reg(CAPR, 16'h1234, "R7 falling ignored in rising mode");
        wr(EVTR, 16'h0001);
        chk_irq(1'b0, "R12 capture irq cleared");
        wr(MODE, 16'h0082);
        wr(CNTR, 16'h3333);
        pin_set(1'b1);
        chk_reg(CAPR, 16'h1234, "R7 rising ignored in falling mode");
        chk_reg(EVTR, 16'h0000, "R7 no event on ignored edge");
        pin_set(1'b0);
        chk_reg(CAPR, 16'h3333, "R7 falling capture");
        wr(EVTR, 16'h0001);
        wr(MODE, 16'h00C2);
        wr(CNTR, 16'h4444);
        pin_set(1'b1);
        chk_reg(CAPR, 16'h4444, "R7 both edges rise");
        wr(CNTR, 16'h5555);
        pin_set(1'b0);
        chk_reg(CAPR, 16'h5555, "R7 both edges fall");
        wr(EVTR, 16'h0001);
        wr(MODE, 16'h0002);
        wr(CNTR, 16'h6666);
        pin_set(1'b1);
        pin_set(1'b0);
        chk_reg(CAPR, 16'h5555, "R7 capture disabled");
        chk_reg(EVTR, 16'h0000, "R7 no event when disabled");
        wr(CAPR, 16'hABCD);
        chk_reg(CAPR, 16'h5555, "R10 capture write ignored");

        // R4 external pin source, divide by 2, six rising edges give 3
        wr(CTRL, 16'h0000);
        wr(REFR, 16'hFFFF);
        wr(MODE, 16'h0106);
        wr(CTRL, 16'h0001);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); tmr_pin = 1'b1; idle(3);
            @(negedge clk); tmr_pin = 1'b0; idle(3);
        end
        idle(4);
        chk_reg(CNTR, 16'd3, "R4 external pin ticks");

        // R3 code 00 yields no ticks
        wr(CTRL, 16'h0000);
        wr(MODE, 16'h0000);
        wr(CTRL, 16'h0001);
        idle(20);
        chk_reg(CNTR, 16'd0, "R3 no source no count");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule